// File: doc/BRIEF.md
# Instruction Operand Readiness Tracker

This block holds the timing state of a single in-flight instruction. After dispatch, each source operand waits for one or more producing writes. Every producer reports its remaining latency and a per-consumer read-advance value. The wait for that producer is the latency minus the advance, floored at zero. A source with several producers, as happens with partial-register merges, keeps the largest wait it has seen. That largest wait counts down while producers are still outstanding. Once the last producer has reported, the source loads it into its own countdown.

An instruction whose destinations carry a partial-register dependency has a further condition. It may become ready only when the write it depends on has a known remaining time that is strictly below the instruction's own latency. After issue, the instruction counts down its latency. Each destination counts down its own signed latency, and the instruction reports executed when the instruction counter runs out. A `tick_i` pulse marks one model cycle and is the only thing that advances the countdowns.

Top module: `opnd_ready_slot`

## Requirements
- R1: A synchronous active-high `rst` puts the slot in stage 0 (invalid), drives all three flags low, sets every `dst_left_o` field to all ones (-1, unknown) and clears all source pending counts.
- R2: `dispatch_i` is accepted only in stage 0. It loads each source's pending count from `src_deps_i` and latches `max_lat_i`. The next stage is 2 (ready) if every pending count is zero and the destination check of R5 passes using `max_lat_i`; otherwise it is 1 (available). In any other stage `dispatch_i` has no effect.
- R3: In stage 1, a `note_vld_i[s]` pulse for a source whose pending count is nonzero decrements that count. The source keeps the maximum of its accumulated wait and max(0, `note_lat_i[s]` − `note_adv_i[s]`), with both fields 8-bit signed. When the count reaches zero, the source's countdown loads that maximum, and the source is ready if the maximum is zero. Notifications in other stages, or to a source with a zero count, are ignored.
- R4: On each `tick_i` in stage 1, a source steps after any notification in the same cycle. If producers are still pending and the accumulated wait is nonzero, the wait decrements. Otherwise a known, nonzero countdown decrements and the source becomes ready when it reaches zero. An unknown countdown is left unchanged.
- R5: In stage 1, readiness is evaluated only on a `tick_i`, after the sources have stepped. The slot moves to stage 2 when every source is ready and, for every destination d with `dst_dep_vld_i[d]` set, the signed value `dst_dep_left_i[d]` is at least 0 and below the latched maximum latency.
- R6: Stage 2 is held until `issue_i`. `issue_i` in any other stage has no effect.
- R7: `issue_i` in stage 2 loads the instruction counter with the latched maximum latency and loads each `dst_left_o[d]` from `dst_lat_i[d]`. It enters stage 3 (executing), or stage 4 (executed) directly when the latency is zero.
- R8: On each `tick_i` in stage 3, the instruction counter and each destination counter decrement. The stage becomes 4 on the tick that brings the instruction counter to zero.
- R9: Stage 4 is held until reset. `dispatch_i`, `issue_i` and `tick_i` have no effect on it.
- R10: `ready_o`, `executing_o` and `executed_o` are high exactly in stages 2, 3 and 4 respectively. At most one of them is high at a time.
- R11: Destination counters are 8-bit signed. A counter holding -1 (unknown) is never decremented, so a counter that steps from 0 to -1 stays at -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dispatch_i | input | 1 | Dispatch the slot (stage 0 only) |
| max_lat_i | input | LAT_W | Instruction maximum latency, latched on dispatch |
| src_deps_i | input | NUM_SRC*CNT_W | Per-source count of producing writes, loaded on dispatch |
| note_vld_i | input | NUM_SRC | Per-source producer-start notification |
| note_lat_i | input | NUM_SRC*LAT_W | Signed producer remaining latency per source |
| note_adv_i | input | NUM_SRC*LAT_W | Signed read-advance per source |
| dst_dep_vld_i | input | NUM_DST | Destination has a partial-write dependency |
| dst_dep_left_i | input | NUM_DST*LAT_W | Signed remaining cycles of the dependent write (-1 unknown) |
| tick_i | input | 1 | One model cycle elapses |
| issue_i | input | 1 | Issue the slot (stage 2 only) |
| dst_lat_i | input | NUM_DST*LAT_W | Signed destination latencies, loaded on issue |
| stage_o | output | 3 | Stage: 0 invalid, 1 available, 2 ready, 3 executing, 4 executed |
| ready_o | output | 1 | Stage is 2 |
| executing_o | output | 1 | Stage is 3 |
| executed_o | output | 1 | Stage is 4 |
| dst_left_o | output | NUM_DST*LAT_W | Signed destination remaining cycles |

## Verification
Every result is registered. A dispatch, notification, tick, issue or reset shows up on `stage_o`, the flags and `dst_left_o` right after the rising edge that samples it, and combinations of inputs in one cycle are resolved within that same edge. The bench drives inputs 1 ns after an edge. At the next edge it advances a reference model in bench functions with the inputs the design has just sampled, and it compares all outputs 1 ns later. Directed sequences pin down exact cycle counts for a negative read-advance, a multi-producer merge, the accumulated-wait countdown and the dependent-write bound.

// File: rtl/orr_pkg.sv
package orr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_AVAIL = 3'd1,
    ST_READY = 3'd2,
    ST_EXEC  = 3'd3,
    ST_DONE  = 3'd4
  } stage_e;

  // Wait seen by one consumer: producer latency less read-advance, not below zero.
  function automatic int wait_cycles(input int lat, input int adv);
    int diff;
    diff = lat - adv;
    return (diff > 0) ? diff : 0;
  endfunction

  // A dependent write must be known and finish strictly earlier than our latency.
  function automatic logic dep_clear(input int dep_left, input int own_lat);
    return (dep_left >= 0) && (dep_left < own_lat);
  endfunction

endpackage

// File: rtl/orr_src_track.sv
module orr_src_track
  import orr_pkg::*;
#(
  parameter int LAT_W = 8,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] deps_i,
  input  logic             active_i,
  input  logic             step_i,
  input  logic             note_vld_i,
  input  logic [LAT_W-1:0] note_lat_i,
  input  logic [LAT_W-1:0] note_adv_i,
  output logic             rdy_nxt_o
);
  localparam int WW = LAT_W + 1;
  localparam logic [WW-1:0] UNK = '1;

  logic [CNT_W-1:0] pend_q, pend_n;
  logic [WW-1:0]    acc_q, acc_n;
  logic [WW-1:0]    left_q, left_n;
  logic             rdy_q, rdy_n;
  logic [WW-1:0]    note_wait;
  logic             note_take;
  logic             acc_step;
  logic             left_step;

  assign note_wait = WW'(wait_cycles(int'($signed(note_lat_i)), int'($signed(note_adv_i))));

  always_comb begin
    pend_n    = pend_q;
    acc_n     = acc_q;
    left_n    = left_q;
    rdy_n     = rdy_q;
    note_take = 1'b0;
    acc_step  = 1'b0;
    left_step = 1'b0;
    if (load_i) begin
      pend_n = deps_i;
      acc_n  = '0;
      left_n = (deps_i == '0) ? '0 : UNK;
      rdy_n  = (deps_i == '0);
    end else if (active_i) begin
      if (note_vld_i && (pend_q != '0)) begin
        note_take = 1'b1;
        pend_n    = pend_q - 1'b1;
        if (note_wait > acc_q) acc_n = note_wait;
        if (pend_n == '0) begin
          left_n = acc_n;
          rdy_n  = (acc_n == '0);
        end
      end
      if (step_i) begin
        if ((pend_n != '0) && (acc_n != '0)) begin
          acc_step = 1'b1;
          acc_n    = acc_n - 1'b1;
        end else if ((left_n != UNK) && (left_n != '0)) begin
          left_step = 1'b1;
          left_n    = left_n - 1'b1;
          rdy_n     = (left_n == '0);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      acc_q  <= '0;
      left_q <= UNK;
      rdy_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      acc_q  <= acc_n;
      left_q <= left_n;
      rdy_q  <= rdy_n;
    end
  end

  assign rdy_nxt_o = rdy_n;

  // R4: a ready source has no producers left and an exhausted countdown
  a_r4_ready_is_drained: assert property (@(posedge clk) disable iff (rst)
    rdy_q |-> ((pend_q == '0) && (left_q == '0)));

  // R3: once ready, a source stays ready until the next dispatch
  a_r3_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    (rdy_q && !load_i) |=> rdy_q);

  // R4: an unknown countdown is never stepped
  a_r4_unknown_untouched: assert property (@(posedge clk) disable iff (rst)
    (left_q == UNK && !load_i && !note_take) |=> (left_q == UNK));

  // R4: stepping the accumulated wait and the countdown never coincide
  a_r4_one_step: assert property (@(posedge clk) disable iff (rst)
    !(acc_step && left_step));
endmodule

// File: rtl/orr_dst_cnt.sv
module orr_dst_cnt #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic             step_i,
  output logic [LAT_W-1:0] left_o
);
  localparam logic [LAT_W-1:0] UNK = '1;

  logic [LAT_W-1:0] left_q;
  logic             can_dec;

  assign can_dec = step_i && (left_q != UNK);

  always_ff @(posedge clk) begin
    if (rst)          left_q <= UNK;
    else if (load_i)  left_q <= lat_i;
    else if (can_dec) left_q <= left_q - 1'b1;
  end

  assign left_o = left_q;

  // R11: an unknown destination counter stays unknown until reloaded
  a_r11_unknown_frozen: assert property (@(posedge clk) disable iff (rst)
    (left_q == UNK && !load_i) |=> (left_q == UNK));

  // R8: with no load and no step the counter holds
  a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !step_i) |=> $stable(left_q));
endmodule

// File: rtl/orr_stage_ctrl.sv
module orr_stage_ctrl
  import orr_pkg::*;
#(
  parameter int LAT_W   = 8,
  parameter int NUM_DST = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          dispatch_i,
  input  logic                          issue_i,
  input  logic                          tick_i,
  input  logic [LAT_W-1:0]              max_lat_i,
  input  logic                          src_all_rdy_i,
  input  logic [NUM_DST-1:0]            dst_dep_vld_i,
  input  logic [NUM_DST-1:0][LAT_W-1:0] dst_dep_left_i,
  output stage_e                        stage_o,
  output logic                          src_load_o,
  output logic                          src_active_o,
  output logic                          dst_load_o,
  output logic                          dst_step_o
);
  stage_e           stage_q, stage_n;
  logic [LAT_W-1:0] lat_q;
  logic [LAT_W-1:0] ctr_q, ctr_n;
  logic [LAT_W-1:0] lat_eval;
  logic [NUM_DST-1:0] dst_ok;
  logic             dst_all_ok;
  logic             disp_ok, issue_ok, avail_tick, exec_tick, go_ready;

  assign lat_eval   = (stage_q == ST_IDLE) ? max_lat_i : lat_q;

  for (genvar d = 0; d < NUM_DST; d++) begin : g_dst_chk
    assign dst_ok[d] = !dst_dep_vld_i[d] ||
                       dep_clear(int'($signed(dst_dep_left_i[d])), int'(lat_eval));
  end
  assign dst_all_ok = &dst_ok;

  assign disp_ok    = (stage_q == ST_IDLE)  && dispatch_i;
  assign issue_ok   = (stage_q == ST_READY) && issue_i;
  assign avail_tick = (stage_q == ST_AVAIL) && tick_i;
  assign exec_tick  = (stage_q == ST_EXEC)  && tick_i;
  assign go_ready   = src_all_rdy_i && dst_all_ok;

  always_comb begin
    stage_n = stage_q;
    ctr_n   = ctr_q;
    unique case (stage_q)
      ST_IDLE:  if (disp_ok)    stage_n = go_ready ? ST_READY : ST_AVAIL;
      ST_AVAIL: if (avail_tick && go_ready) stage_n = ST_READY;
      ST_READY: if (issue_ok) begin
        ctr_n   = lat_q;
        stage_n = (lat_q == '0) ? ST_DONE : ST_EXEC;
      end
      ST_EXEC:  if (exec_tick) begin
        ctr_n = ctr_q - 1'b1;
        if (ctr_n == '0) stage_n = ST_DONE;
      end
      default:  stage_n = stage_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= ST_IDLE;
      lat_q   <= '0;
      ctr_q   <= '0;
    end else begin
      stage_q <= stage_n;
      ctr_q   <= ctr_n;
      if (disp_ok) lat_q <= max_lat_i;
    end
  end

  assign stage_o      = stage_q;
  assign src_load_o   = disp_ok;
  assign src_active_o = (stage_q == ST_AVAIL);
  assign dst_load_o   = issue_ok;
  assign dst_step_o   = exec_tick;

  // R2: dispatch from invalid always leaves invalid
  a_r2_dispatch_leaves_idle: assert property (@(posedge clk) disable iff (rst)
    (stage_q == ST_IDLE && dispatch_i) |=> (stage_q == ST_AVAIL || stage_q == ST_READY));

  // R2: only reset returns the slot to invalid
  a_r2_no_return_to_idle: assert property (@(posedge clk) disable iff (rst)
    (stage_q != ST_IDLE) |=> (stage_q != ST_IDLE));

  // R6: ready holds while no issue arrives
  a_r6_ready_holds: assert property (@(posedge clk) disable iff (rst)
    (stage_q == ST_READY && !issue_i) |=> (stage_q == ST_READY));

  // R7: a zero-latency issue goes straight to executed
  a_r7_zero_latency: assert property (@(posedge clk) disable iff (rst)
    (stage_q == ST_READY && issue_i && lat_q == '0) |=> (stage_q == ST_DONE));

  // R8: the final tick of execution ends in executed
  a_r8_last_tick: assert property (@(posedge clk) disable iff (rst)
    (stage_q == ST_EXEC && tick_i && ctr_q == LAT_W'(1)) |=> (stage_q == ST_DONE));

  // R8: executing never sees a zero counter
  a_r8_ctr_live: assert property (@(posedge clk) disable iff (rst)
    (stage_q == ST_EXEC) |-> (ctr_q != '0));

  // R9: executed is terminal until reset
  a_r9_done_holds: assert property (@(posedge clk) disable iff (rst)
    (stage_q == ST_DONE) |=> (stage_q == ST_DONE));
endmodule

// File: rtl/opnd_ready_slot.sv
module opnd_ready_slot
  import orr_pkg::*;
#(
  parameter int NUM_SRC  = 3,
  parameter int NUM_DST  = 2,
  parameter int LAT_W    = 8,
  parameter int MAX_DEPS = 3,
  localparam int CNT_W   = $clog2(MAX_DEPS + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          dispatch_i,
  input  logic [LAT_W-1:0]              max_lat_i,
  input  logic [NUM_SRC-1:0][CNT_W-1:0] src_deps_i,
  input  logic [NUM_SRC-1:0]            note_vld_i,
  input  logic [NUM_SRC-1:0][LAT_W-1:0] note_lat_i,
  input  logic [NUM_SRC-1:0][LAT_W-1:0] note_adv_i,
  input  logic [NUM_DST-1:0]            dst_dep_vld_i,
  input  logic [NUM_DST-1:0][LAT_W-1:0] dst_dep_left_i,
  input  logic                          tick_i,
  input  logic                          issue_i,
  input  logic [NUM_DST-1:0][LAT_W-1:0] dst_lat_i,
  output logic [2:0]                    stage_o,
  output logic                          ready_o,
  output logic                          executing_o,
  output logic                          executed_o,
  output logic [NUM_DST-1:0][LAT_W-1:0] dst_left_o
);
  stage_e             stage;
  logic               src_load, src_active, dst_load, dst_step;
  logic [NUM_SRC-1:0] src_rdy_nxt;

  orr_stage_ctrl #(.LAT_W(LAT_W), .NUM_DST(NUM_DST)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .dispatch_i     (dispatch_i),
    .issue_i        (issue_i),
    .tick_i         (tick_i),
    .max_lat_i      (max_lat_i),
    .src_all_rdy_i  (&src_rdy_nxt),
    .dst_dep_vld_i  (dst_dep_vld_i),
    .dst_dep_left_i (dst_dep_left_i),
    .stage_o        (stage),
    .src_load_o     (src_load),
    .src_active_o   (src_active),
    .dst_load_o     (dst_load),
    .dst_step_o     (dst_step)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    orr_src_track #(.LAT_W(LAT_W), .CNT_W(CNT_W)) u_src (
      .clk        (clk),
      .rst        (rst),
      .load_i     (src_load),
      .deps_i     (src_deps_i[s]),
      .active_i   (src_active),
      .step_i     (tick_i),
      .note_vld_i (note_vld_i[s]),
      .note_lat_i (note_lat_i[s]),
      .note_adv_i (note_adv_i[s]),
      .rdy_nxt_o  (src_rdy_nxt[s])
    );
  end

  for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
    orr_dst_cnt #(.LAT_W(LAT_W)) u_dst (
      .clk    (clk),
      .rst    (rst),
      .load_i (dst_load),
      .lat_i  (dst_lat_i[d]),
      .step_i (dst_step),
      .left_o (dst_left_o[d])
    );
  end

  assign stage_o     = stage;
  assign ready_o     = (stage == ST_READY);
  assign executing_o = (stage == ST_EXEC);
  assign executed_o  = (stage == ST_DONE);

  // R10: the three stage flags are mutually exclusive
  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ready_o, executing_o, executed_o}));

  // R1: the cycle after reset shows the invalid stage
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (stage_o == 3'd0));
endmodule

// File: tb/test_opnd_ready_slot.sv
module test_opnd_ready_slot;
  localparam int NS = 3, ND = 2, LW = 8, CW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic                dispatch, tick, issue;
  logic [LW-1:0]       max_lat;
  logic [NS-1:0][CW-1:0] deps;
  logic [NS-1:0]       nvld;
  logic [NS-1:0][LW-1:0] nlat, nadv;
  logic [ND-1:0]       dvld;
  logic [ND-1:0][LW-1:0] dleft_in, dlat;
  logic [2:0]          stage_o;
  logic                ready_o, executing_o, executed_o;
  logic [ND-1:0][LW-1:0] dst_left_o;

  int b_nlat[NS], b_nadv[NS], b_dep[ND], b_dlat[ND];

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      nlat[s] = LW'(b_nlat[s]);
      nadv[s] = LW'(b_nadv[s]);
    end
    for (int d = 0; d < ND; d++) begin
      dleft_in[d] = LW'(b_dep[d]);
      dlat[d]     = LW'(b_dlat[d]);
    end
  end

  opnd_ready_slot i_opnd_ready_slot (
    .clk(clk), .rst(rst), .dispatch_i(dispatch), .max_lat_i(max_lat),
    .src_deps_i(deps), .note_vld_i(nvld), .note_lat_i(nlat), .note_adv_i(nadv),
    .dst_dep_vld_i(dvld), .dst_dep_left_i(dleft_in), .tick_i(tick), .issue_i(issue),
    .dst_lat_i(dlat), .stage_o(stage_o), .ready_o(ready_o), .executing_o(executing_o),
    .executed_o(executed_o), .dst_left_o(dst_left_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // reference state
  int m_stage, m_lat, m_ctr;
  int m_pend[NS], m_acc[NS], m_cd[NS];
  bit m_rdy[NS];
  int m_dl[ND];
  string m_req;

  function automatic int f_wait(int l, int a);
    return (l - a > 0) ? (l - a) : 0;
  endfunction

  function automatic bit f_dst_ok(int lat);
    bit ok = 1;
    for (int d = 0; d < ND; d++)
      if (dvld[d] && !(b_dep[d] >= 0 && b_dep[d] < lat)) ok = 0;
    return ok;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic model_update();
    bit all;
    if (rst) begin
      m_stage = 0; m_lat = 0; m_ctr = 0; m_req = "R1";
      for (int s = 0; s < NS; s++) begin m_pend[s] = 0; m_acc[s] = 0; m_cd[s] = -1; m_rdy[s] = 0; end
      for (int d = 0; d < ND; d++) m_dl[d] = -1;
      return;
    end
    case (m_stage)
      0: begin
        m_req = "R2";
        if (dispatch) begin
          m_lat = int'(max_lat);
          all = 1;
          for (int s = 0; s < NS; s++) begin
            m_pend[s] = int'(deps[s]); m_acc[s] = 0;
            m_rdy[s]  = (m_pend[s] == 0);
            m_cd[s]   = m_rdy[s] ? 0 : -1;
            all &= m_rdy[s];
          end
          m_stage = (all && f_dst_ok(m_lat)) ? 2 : 1;
        end
      end
      1: begin
        m_req = tick ? "R5" : "R3";
        for (int s = 0; s < NS; s++) begin
          if (nvld[s] && m_pend[s] > 0) begin
            m_pend[s]--;
            if (f_wait(b_nlat[s], b_nadv[s]) > m_acc[s]) m_acc[s] = f_wait(b_nlat[s], b_nadv[s]);
            if (m_pend[s] == 0) begin m_cd[s] = m_acc[s]; m_rdy[s] = (m_acc[s] == 0); end
          end
          if (tick) begin
            if (m_pend[s] > 0 && m_acc[s] > 0) m_acc[s]--;
            else if (m_cd[s] > 0) begin m_cd[s]--; m_rdy[s] = (m_cd[s] == 0); end
          end
        end
        if (tick) begin
          all = 1;
          for (int s = 0; s < NS; s++) all &= m_rdy[s];
          if (all && f_dst_ok(m_lat)) m_stage = 2;
        end
      end
      2: begin
        m_req = "R6";
        if (issue) begin
          m_req = "R7";
          m_ctr = m_lat;
          for (int d = 0; d < ND; d++) m_dl[d] = b_dlat[d];
          m_stage = (m_lat == 0) ? 4 : 3;
        end
      end
      3: begin
        m_req = "R8";
        if (tick) begin
          for (int d = 0; d < ND; d++) if (m_dl[d] != -1) m_dl[d]--;
          m_ctr--;
          if (m_ctr == 0) m_stage = 4;
        end
      end
      default: m_req = "R9";
    endcase
  endtask

  task automatic compare();
    chk(int'(stage_o) == m_stage, m_req, int'(stage_o), m_stage);
    chk(ready_o == (m_stage == 2), "R10 ready_o", int'(ready_o), int'(m_stage == 2));
    chk(executing_o == (m_stage == 3), "R10 executing_o", int'(executing_o), int'(m_stage == 3));
    chk(executed_o == (m_stage == 4), "R10 executed_o", int'(executed_o), int'(m_stage == 4));
    for (int d = 0; d < ND; d++)
      chk(int'($signed(dst_left_o[d])) == m_dl[d], "R8/R11 dst_left", int'($signed(dst_left_o[d])), m_dl[d]);
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    #1;
    compare();
  endtask

  task automatic quiet();
    dispatch = 0; tick = 0; issue = 0; nvld = '0;
  endtask

  task automatic clear_all();
    quiet();
    max_lat = '0; deps = '0; dvld = '0;
    for (int s = 0; s < NS; s++) begin b_nlat[s] = 0; b_nadv[s] = 0; end
    for (int d = 0; d < ND; d++) begin b_dep[d] = 0; b_dlat[d] = 0; end
  endtask

  task automatic do_reset();
    clear_all(); rst = 1; step(); rst = 0;
  endtask

  task automatic note(input int s, input int l, input int a);
    nvld[s] = 1'b1; b_nlat[s] = l; b_nadv[s] = a;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7411));
    clear_all();
    step();
    do_reset();
    // R1 reset state
    chk(stage_o == 3'd0, "R1 stage", int'(stage_o), 0);
    chk(int'($signed(dst_left_o[0])) == -1, "R1 dst_left", int'($signed(dst_left_o[0])), -1);

    // R2 + R7 + R9: immediate ready, zero latency, terminal executed
    deps = '0; max_lat = 8'd0; dispatch = 1; step(); quiet();
    chk(stage_o == 3'd2, "R2 immediate ready", int'(stage_o), 2);
    issue = 1; step(); quiet();
    chk(stage_o == 3'd4, "R7 zero latency", int'(stage_o), 4);
    dispatch = 1; issue = 1; tick = 1; step(); quiet();
    chk(stage_o == 3'd4, "R9 executed held", int'(stage_o), 4);

    // R3/R4: negative read advance, wait 2-(-3)=5
    do_reset();
    deps[0] = 2'd1; max_lat = 8'd3; dispatch = 1; step(); quiet();
    chk(stage_o == 3'd1, "R2 available", int'(stage_o), 1);
    tick = 1; note(0, 2, -3); step(); nvld = '0;
    step(); step(); step();
    chk(stage_o == 3'd1, "R3 negative advance still waiting", int'(stage_o), 1);
    step(); quiet();
    chk(stage_o == 3'd2, "R4 countdown reached zero", int'(stage_o), 2);

    // R5/R6: dependent-write bound, issue ignored while available
    do_reset();
    max_lat = 8'd4; dvld[0] = 1; b_dep[0] = 4; dispatch = 1; step(); quiet();
    chk(stage_o == 3'd1, "R5 dep equal to latency blocks", int'(stage_o), 1);
    b_dep[0] = -1; tick = 1; issue = 1; step();
    chk(stage_o == 3'd1, "R5/R6 unknown dep blocks, issue ignored", int'(stage_o), 1);
    b_dep[0] = 3; issue = 0; step(); quiet();
    chk(stage_o == 3'd2, "R5 dep below latency", int'(stage_o), 2);
    step();
    chk(stage_o == 3'd2, "R6 ready held", int'(stage_o), 2);

    // R3: two producers merged by maximum; readiness only on tick
    do_reset();
    deps[0] = 2'd2; max_lat = 8'd2; dispatch = 1; step(); quiet();
    note(0, 1, 0); step(); quiet();
    note(0, 3, 1); step(); quiet();
    chk(stage_o == 3'd1, "R5 no tick no evaluation", int'(stage_o), 1);
    tick = 1; step();
    chk(stage_o == 3'd1, "R3 max of waits", int'(stage_o), 1);
    step(); quiet();
    chk(stage_o == 3'd2, "R3 merged wait done", int'(stage_o), 2);
    // R7/R8/R11 execution
    b_dlat[0] = 1; b_dlat[1] = 0; issue = 1; step(); quiet();
    chk(int'($signed(dst_left_o[0])) == 1, "R7 dst load", int'($signed(dst_left_o[0])), 1);
    tick = 1; step();
    chk(int'($signed(dst_left_o[0])) == 0, "R8 dst decrement", int'($signed(dst_left_o[0])), 0);
    chk(stage_o == 3'd3, "R8 executing", int'(stage_o), 3);
    step(); quiet();
    chk(int'($signed(dst_left_o[1])) == -1, "R11 unknown frozen", int'($signed(dst_left_o[1])), -1);
    chk(stage_o == 3'd4, "R8 executed", int'(stage_o), 4);

    // R4: accumulated wait counts down while a producer is pending
    do_reset();
    deps[0] = 2'd2; max_lat = 8'd1; dispatch = 1; step(); quiet();
    tick = 1; note(0, 3, 0); step(); nvld = '0;
    step();
    note(0, 0, 0); step(); quiet();
    chk(stage_o == 3'd2, "R4 accumulated wait stepped", int'(stage_o), 2);

    // random phase
    do_reset();
    for (int c = 0; c < 6000; c++) begin
      rst      = (m_stage == 4 && ($urandom % 4) == 0) || (($urandom % 400) == 0);
      dispatch = ($urandom % 3) == 0;
      issue    = ($urandom % 3) == 0;
      tick     = ($urandom % 10) < 7;
      max_lat  = LW'($urandom % 6);
      for (int s = 0; s < NS; s++) begin
        deps[s]   = CW'($urandom % 4);
        nvld[s]   = ($urandom % 10) < 3;
        b_nlat[s] = int'($urandom % 8) - 2;
        b_nadv[s] = int'($urandom % 9) - 4;
      end
      for (int d = 0; d < ND; d++) begin
        int r = int'($urandom % 10);
        dvld[d]   = ($urandom % 3) == 0;
        b_dep[d]  = (r == 0) ? -1 : (r == 1) ? -3 : int'($urandom % 8);
        b_dlat[d] = int'($urandom % 8);
      end
      step();
    end
    rst = 0;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule